// File: doc/BRIEF.md
# Bus Register with Readback

This block is an eight-bit storage register that hangs on a shared two-way data bus. When its active-low capture enable is asserted, each rising clock edge loads whatever is on the bus. With the capture enable asserted, a second active-low strobe turns the register into a bus talker: it drives the word it holds back onto the same bus, so a bus master can confirm what was written. When the capture enable is deasserted, the register keeps its word and leaves the bus alone.

A separate output bus always carries the stored word. A sense input selects whether that word appears as stored or with every bit inverted. A disable input floats this output bus. The disable only affects the output drivers: the register still loads, holds and clears while the output is floating. An active-low clear zeroes the stored word at once, with no clock needed, and wins over any capture.

Integration rule: the capture enable may only change during the clock's high phase. A change while the clock is low can create a spurious load. The block carries a check that reports any violation.

Top module: `bus_readback_reg`

## Requirements
- R1: While `cap_en_n_i` is low at a rising edge of `clk_i`, the word on `dbus_io` is stored and shows on `qbus_o` after that edge.
- R2: While `cap_en_n_i` and `rb_n_i` are both low, `dbus_io` carries the true stored word, regardless of `q_true_i` and `q_off_i`.
- R3: While `cap_en_n_i` is high, rising edges leave the stored word unchanged and the block does not drive `dbus_io`, even if `rb_n_i` is low.
- R4: While `rb_n_i` is high, the block does not drive `dbus_io`, so an outside source can drive it.
- R5: With `q_off_i` low, `qbus_o` equals the stored word when `q_true_i` is 1 and its bitwise inverse when `q_true_i` is 0.
- R6: With `q_off_i` high, every bit of `qbus_o` is high impedance. Capturing and holding continue unchanged while the output floats.
- R7: A low level on `clear_n_i` zeroes the stored word immediately, without waiting for a clock edge. While it stays low, the word stays zero even with capture enabled at a clock edge.
- R8: While `clear_n_i` is low and `q_off_i` is low, `qbus_o` reads 8'h00 when `q_true_i` is 1 and 8'hFF when `q_true_i` is 0.
- R9: `cap_en_n_i` changes only while `clk_i` is high. The block carries a check that flags a change made during the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; loads on the rising edge |
| clear_n_i | input | 1 | Asynchronous clear, active low |
| cap_en_n_i | input | 1 | Capture and readback enable, active low |
| rb_n_i | input | 1 | Readback strobe, active low |
| q_true_i | input | 1 | Output sense: 1 gives the true word, 0 gives the inverted word |
| q_off_i | input | 1 | High floats the output bus |
| dbus_io | inout | 8 | Shared data bus: loaded from, driven during readback |
| qbus_o | output | 8 | Stored word after the polarity choice, three-state |

## Verification
Several properties are checked on every clock edge, outside clear:
- capture-enabled edges load the sampled bus word, and disabled edges hold it;
- the bus carries the stored word whenever readback is active;
- the output bus follows the selected polarity while it is enabled;
- the capture enable never changes during the clock's low phase.

Some behaviours are only visible in the bench's scenarios, because they depend on bus resolution or on ordering across edges:
- the bus and output actually float, which shows as values from bench pull-ups;
- the clear takes effect between edges and overrides an edge where capture is enabled;
- capture continues while the output is floating, seen once the output is re-enabled.

// File: rtl/brr_pkg.sv
package brr_pkg;

  // Who owns the shared data bus in the current cycle.
  typedef enum logic {
    BUS_RELEASED = 1'b0,
    BUS_TALKING  = 1'b1
  } bus_mode_e;

  // Readback needs both active-low strobes asserted together.
  function automatic bus_mode_e pick_bus_mode(logic cap_en_n, logic rb_n);
    return (!cap_en_n && !rb_n) ? BUS_TALKING : BUS_RELEASED;
  endfunction

  // A rising edge stores only while the capture enable is asserted.
  function automatic logic load_this_edge(logic cap_en_n);
    return !cap_en_n;
  endfunction

endpackage

// File: rtl/brr_store.sv
module brr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clear_n_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] word_o
);

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk_i or negedge clear_n_i) begin
    if (!clear_n_i)   word_q <= '0;
    else if (load_i)  word_q <= din_i;
  end

  assign word_o = word_q;

  // R1: an enabled edge takes the word sampled on the bus
  p_load_takes_bus_r1: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    load_i |=> (word_o == $past(din_i)))
    else $error("store: enabled edge did not load bus word");

  // R3: a disabled edge holds the word
  p_hold_when_idle_r3: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    !load_i |=> $stable(word_o))
    else $error("store: word changed on disabled edge");

  // R7: clear keeps the word at zero on every edge it covers
  p_clear_zero_r7: assert property (@(posedge clk_i)
    !clear_n_i |-> (word_o == '0))
    else $error("store: word nonzero under clear");

endmodule

// File: rtl/brr_readback.sv
module brr_readback
  import brr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clear_n_i,
  input  bus_mode_e        mode_i,
  input  logic [WIDTH-1:0] word_i,
  inout  wire  [WIDTH-1:0] dbus_io
);

  logic talk_w;
  assign talk_w = (mode_i == BUS_TALKING);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign dbus_io[b] = talk_w ? word_i[b] : 1'bz;
  end

  // R2: during readback the bus carries the true stored word
  p_bus_echo_r2: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    talk_w |-> (dbus_io == word_i))
    else $error("readback: bus differs from stored word");

endmodule

// File: rtl/brr_qstage.sv
module brr_qstage #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clear_n_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             q_true_i,
  input  logic             q_off_i,
  output wire  [WIDTH-1:0] qbus_o
);

  // Sense choice: 1 keeps the word, 0 flips every bit.
  function automatic logic [WIDTH-1:0] apply_sense(logic keep, logic [WIDTH-1:0] w);
    return keep ? w : ~w;
  endfunction

  logic [WIDTH-1:0] shaped_w;
  assign shaped_w = apply_sense(q_true_i, word_i);

  for (genvar b = 0; b < WIDTH; b++) begin : g_drv
    assign qbus_o[b] = q_off_i ? 1'bz : shaped_w[b];
  end

  // R5: true sense shows the word itself
  p_true_sense_r5: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    (!q_off_i && q_true_i) |-> (qbus_o == word_i))
    else $error("qstage: true sense mismatch");

  // R5: inverted sense shows the complement
  p_inv_sense_r5: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    (!q_off_i && !q_true_i) |-> ((qbus_o ^ word_i) == {WIDTH{1'b1}}))
    else $error("qstage: inverted sense mismatch");

endmodule

// File: rtl/bus_readback_reg.sv
module bus_readback_reg
  import brr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clear_n_i,
  input  logic             cap_en_n_i,
  input  logic             rb_n_i,
  input  logic             q_true_i,
  input  logic             q_off_i,
  inout  wire  [WIDTH-1:0] dbus_io,
  output wire  [WIDTH-1:0] qbus_o
);

  // Named internal events, visible to the checks.
  logic             load_w;
  bus_mode_e        mode_w;
  logic [WIDTH-1:0] word_w;

  assign load_w = load_this_edge(cap_en_n_i);
  assign mode_w = pick_bus_mode(cap_en_n_i, rb_n_i);

  brr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .clear_n_i (clear_n_i),
    .load_i    (load_w),
    .din_i     (dbus_io),
    .word_o    (word_w)
  );

  brr_readback #(.WIDTH(WIDTH)) u_readback (
    .clk_i     (clk_i),
    .clear_n_i (clear_n_i),
    .mode_i    (mode_w),
    .word_i    (word_w),
    .dbus_io   (dbus_io)
  );

  brr_qstage #(.WIDTH(WIDTH)) u_qstage (
    .clk_i     (clk_i),
    .clear_n_i (clear_n_i),
    .word_i    (word_w),
    .q_true_i  (q_true_i),
    .q_off_i   (q_off_i),
    .qbus_o    (qbus_o)
  );

  // Usage-rule monitor: remember the enable level seen at each falling
  // edge. A correct driver keeps it unchanged through the low phase.
  logic en_at_fall_q;
  logic armed_q;

  always_ff @(negedge clk_i or negedge clear_n_i) begin
    if (!clear_n_i) begin
      en_at_fall_q <= 1'b1;
      armed_q      <= 1'b0;
    end else begin
      en_at_fall_q <= cap_en_n_i;
      armed_q      <= 1'b1;
    end
  end

  // R9: enable did not move while the clock was low
  p_en_low_phase_r9: assert property (@(posedge clk_i) disable iff (!clear_n_i || !armed_q)
    cap_en_n_i == en_at_fall_q)
    else $error("enable changed during clock low phase");

endmodule

// File: tb/test_bus_readback_reg.sv
module test_bus_readback_reg;

  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 2000;

  logic clk = 1'b0;
  logic clear_n = 1'b0;
  logic en_n = 1'b1;
  logic rb_n = 1'b1;
  logic qt = 1'b1;
  logic off = 1'b0;
  logic tb_drv = 1'b0;
  logic [W-1:0] tb_val = '0;

  wire [W-1:0] dbus;
  wire [W-1:0] qnet;

  assign dbus = tb_drv ? tb_val : {W{1'bz}};

  // Pull-ups make a floating bus read all ones.
  for (genvar b = 0; b < W; b++) begin : g_pu
    pullup (dbus[b]);
    pullup (qnet[b]);
  end

  always #10 clk = ~clk;

  bus_readback_reg #(.WIDTH(W)) i_bus_readback_reg (
    .clk_i      (clk),
    .clear_n_i  (clear_n),
    .cap_en_n_i (en_n),
    .rb_n_i     (rb_n),
    .q_true_i   (qt),
    .q_off_i    (off),
    .dbus_io    (dbus),
    .qbus_o     (qnet)
  );

  int total = 0;
  int bad = 0;
  int en_viol = 0;
  logic [W-1:0] model = '0;

  // Stimulus monitor for the usage rule (R9).
  always @(en_n) if ($time > 0 && !clk) en_viol++;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic         en_n;
    logic         rb_n;
    logic         qt;
    logic         off;
    logic         drv;
    logic [W-1:0] val;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0F},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h12},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hC3},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  function automatic logic [W-1:0] exp_q(logic o, logic t, logic [W-1:0] m);
    if (o) return {W{1'b1}};
    return t ? m : ~m;
  endfunction

  function automatic logic [W-1:0] exp_bus(logic e, logic r, logic d,
                                           logic [W-1:0] v, logic [W-1:0] m);
    if (!e && !r) return m;
    if (d) return v;
    return {W{1'b1}};
  endfunction

  logic finished = 1'b0;

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset state, R7 and R8
    @(posedge clk); #15;
    check("R7 reset q true sense", qnet, 8'h00);
    @(posedge clk); #5 qt = 1'b0; #10;
    check("R8 reset q inverted sense", qnet, 8'hFF);
    @(posedge clk); #5 clear_n = 1'b1; qt = 1'b1; #10;
    check("R7 after release q", qnet, 8'h00);

    // Vector walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #5;
      en_n = VECS[i].en_n; rb_n = VECS[i].rb_n; qt = VECS[i].qt;
      off = VECS[i].off; tb_drv = VECS[i].drv; tb_val = VECS[i].val;
      #10;
      check("R1/R5/R6 qbus", qnet, exp_q(VECS[i].off, VECS[i].qt, model));
      check("R2/R3/R4 dbus", dbus,
            exp_bus(VECS[i].en_n, VECS[i].rb_n, VECS[i].drv, VECS[i].val, model));
      if (!VECS[i].en_n)
        model = exp_bus(VECS[i].en_n, VECS[i].rb_n, VECS[i].drv, VECS[i].val, model);
    end

    // Directed: async clear between edges, R7
    @(posedge clk); #5 en_n = 1'b1; tb_drv = 1'b0; qt = 1'b1; off = 1'b0; #10;
    check("R1 final captured word", qnet, model);
    clear_n = 1'b0; #2;
    check("R7 clear without clock", qnet, 8'h00);
    // Clear overrides an enabled edge
    @(posedge clk); #5 en_n = 1'b0; rb_n = 1'b1; tb_drv = 1'b1; tb_val = 8'h77; #10;
    check("R7 clear beats capture", qnet, 8'h00);
    @(posedge clk); #5 qt = 1'b0; #10;
    check("R8 cleared inverted q", qnet, 8'hFF);
    @(posedge clk); #5 en_n = 1'b1; tb_drv = 1'b0; clear_n = 1'b1; qt = 1'b1; #10;
    check("R7 word zero after clear", qnet, 8'h00);

    // Capture while floating, then reveal: R6
    @(posedge clk); #5 off = 1'b1; en_n = 1'b0; tb_drv = 1'b1; tb_val = 8'h69; #10;
    check("R6 floating q", qnet, 8'hFF);
    @(posedge clk); #5 en_n = 1'b1; tb_drv = 1'b0; #10;
    check("R6 floating q hold", qnet, 8'hFF);
    @(posedge clk); #5 off = 1'b0; #10;
    check("R6 captured while floating", qnet, 8'h69);

    // Stimulus respected the enable rule: R9
    check("R9 enable changes in high phase", 8'(en_viol), 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule